// File: doc/BRIEF.md
# Restoring Unsigned Divider

This block divides a double-width unsigned dividend by a single-width unsigned divisor over several clock cycles and returns a single-width quotient and a single-width remainder. It works one quotient bit per step. Each step shifts the partial remainder left to take in the next dividend bit, then subtracts the divisor. The sign of that difference is the only comparison the block makes. When the difference is negative, a separate cycle adds the divisor back to recover the previous value, and the quotient bit is 0. When the difference is not negative, the quotient bit is 1 and no extra cycle is spent.

A caller pulses `start` while the block is idle. `busy` then stays high for the whole division, and a one-cycle `done` marks the cycle in which the results are valid. Two cases finish in the cycle after the request and run no steps:
- A zero divisor raises `div_zero`.
- A quotient too wide for `W` bits raises `ovf`.

In both cases the quotient and remainder read zero.

Top module: `rdiv_unit`

## Requirements
- R1: After reset, `busy`, `done`, `div_zero` and `ovf` are all 0.
- R2: A `start` seen while `busy` is 1 is ignored: the running division keeps its operands, its result and its latency.
- R3: A request whose divisor is 0 ends with `done`=1 and `div_zero`=1 in the cycle after the request, with `ovf`=0 and the quotient and remainder both 0.
- R4: A request with a non-zero divisor whose upper `W` dividend bits are greater than or equal to the divisor ends with `done`=1 and `ovf`=1 in the cycle after the request, with `div_zero`=0 and the quotient and remainder both 0.
- R5: Any other request gives a quotient and remainder that satisfy quotient × divisor + remainder = dividend and remainder < divisor, with both flags 0.
- R6: A normal division takes `W` + z clock edges from the edge that accepts `start` to the edge that raises `done`, where z is the number of 0 bits in the quotient. Each 0 bit costs one extra restore cycle.
- R7: `busy` is 1 from the cycle after a normal request is accepted until `done` rises. `done` lasts one cycle, and `busy` is 0 while `done` is 1.
- R8: After `done`, the quotient, remainder and both flags hold their values until the next accepted `start`, whatever the operand inputs do.
- R9: At `W`=4, dividend 1001_0011 (147) divided by 1011 (11) gives quotient 1101 (13) and remainder 0100 (4), and takes 5 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division (taken only when idle) |
| dividend | input | 2W | Unsigned dividend, sampled on the accepting edge |
| divisor | input | W | Unsigned divisor, sampled on the accepting edge |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: results valid |
| quotient | output | W | Quotient (held after `done`) |
| remainder | output | W | Remainder (held after `done`) |
| div_zero | output | 1 | Last request had a zero divisor |
| ovf | output | 1 | Last request's quotient did not fit in `W` bits |

## Verification
The assertions assume two things about the inputs. First, a request counts as accepted exactly when `start` is high while `busy` is low. Second, the divisor that the remainder check compares against is the one present on that accepting edge, so the checker latches it there. The stimulus follows these rules: it drives `start` for one cycle, changes operands only after the accepting edge, and scrambles the operand inputs both during a division and after `done`. The stimulus covers every dividend and divisor pair at `W`=4, which covers every zero-divisor and overflow case. It also adds a deliberate `start` pulse in the middle of a division.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_TRIAL   = 2'd1,
    ST_RESTORE = 2'd2
  } rdiv_state_e;
endpackage

// File: rtl/rdiv_trial.sv
// Combinational step datapath: shift in one dividend bit, trial-subtract,
// and the add-back value used by a restore cycle.
module rdiv_trial #(
  parameter int W = 4
) (
  input  logic [W+1:0] part,
  input  logic         next_bit,
  input  logic [W-1:0] divisor,
  output logic [W+1:0] trial_diff,
  output logic         trial_neg,
  output logic [W+1:0] restored
);
  logic [W+1:0] shifted;
  logic [W+1:0] dvs_ext;

  always_comb begin
    dvs_ext    = {2'b00, divisor};
    shifted    = {1'b0, part[W-1:0], next_bit};
    trial_diff = shifted - dvs_ext;
    trial_neg  = trial_diff[W+1];
    restored   = part + dvs_ext;
  end
endmodule

// File: rtl/rdiv_ctrl.sv
// Sequencer: accepts requests, counts steps, inserts restore cycles.
module rdiv_ctrl
  import rdiv_pkg::*;
#(
  parameter int W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic early_exit,
  input  logic trial_neg,
  output logic accept,
  output logic do_trial,
  output logic do_restore,
  output logic busy,
  output logic done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  rdiv_state_e state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;
  logic          done_n;

  assign accept     = (state_q == ST_IDLE) && start;
  assign do_trial   = (state_q == ST_TRIAL);
  assign do_restore = (state_q == ST_RESTORE);
  assign busy       = (state_q != ST_IDLE);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    cnt_en  = 1'b0;
    done_n  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (early_exit) begin
            done_n = 1'b1;
          end else begin
            state_n = ST_TRIAL;
            cnt_n   = '0;
            cnt_en  = 1'b1;
          end
        end
      end
      ST_TRIAL: begin
        if (trial_neg) begin
          state_n = ST_RESTORE;
        end else if (cnt_q == LAST) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
        end else begin
          cnt_n  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      ST_RESTORE: begin
        if (cnt_q == LAST) begin
          state_n = ST_IDLE;
          done_n  = 1'b1;
        end else begin
          state_n = ST_TRIAL;
          cnt_n   = cnt_q + 1'b1;
          cnt_en  = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_n;
      done    <= done_n;
      if (cnt_en) cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/rdiv_unit.sv
module rdiv_unit #(
  parameter int W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic           busy,
  output logic           done,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder,
  output logic           div_zero,
  output logic           ovf
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [W-1:0] hi_half, lo_half;
  logic         dvs_zero, hi_ge;
  logic         early_exit;
  logic         accept, do_trial, do_restore, trial_neg;
  logic [W+1:0] trial_diff, restored;

  logic [W+1:0] part_q, part_n;
  logic [W-1:0] low_q, low_n;
  logic         dz_q, dz_n, ovf_q, ovf_n;
  logic         part_en, low_en, flag_en;

  assign hi_half    = dividend[2*W-1:W];
  assign lo_half    = dividend[W-1:0];
  assign dvs_zero   = (divisor == '0);
  assign hi_ge      = (hi_half >= divisor);
  assign early_exit = dvs_zero | hi_ge;

  rdiv_ctrl #(.W(W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .early_exit (early_exit),
    .trial_neg  (trial_neg),
    .accept     (accept),
    .do_trial   (do_trial),
    .do_restore (do_restore),
    .busy       (busy),
    .done       (done)
  );

  rdiv_trial #(.W(W)) u_trial (
    .part       (part_q),
    .next_bit   (low_q[W-1]),
    .divisor    (divisor_q),
    .trial_diff (trial_diff),
    .trial_neg  (trial_neg),
    .restored   (restored)
  );

  // Divisor captured at acceptance so the input may change mid-division.
  logic [W-1:0] divisor_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)                 divisor_q <= '0;
    else if (accept && !early_exit)  divisor_q <= divisor;
  end

  always_comb begin
    part_n  = part_q;
    low_n   = low_q;
    dz_n    = dz_q;
    ovf_n   = ovf_q;
    part_en = 1'b0;
    low_en  = 1'b0;
    flag_en = 1'b0;
    if (accept) begin
      part_en = 1'b1;
      low_en  = 1'b1;
      flag_en = 1'b1;
      dz_n    = dvs_zero;
      ovf_n   = !dvs_zero && hi_ge;
      if (early_exit) begin
        part_n = '0;
        low_n  = '0;
      end else begin
        part_n = {2'b00, hi_half};
        low_n  = lo_half;
      end
    end else if (do_trial) begin
      low_en  = 1'b1;
      low_n   = {low_q[W-2:0], ~trial_neg};
      part_en = 1'b1;
      part_n  = trial_diff;
    end else if (do_restore) begin
      part_en = 1'b1;
      part_n  = restored;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      part_q <= '0;
      low_q  <= '0;
      dz_q   <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (part_en) part_q <= part_n;
      if (low_en)  low_q  <= low_n;
      if (flag_en) begin
        dz_q  <= dz_n;
        ovf_q <= ovf_n;
      end
    end
  end

  assign quotient  = low_q;
  assign remainder = part_q[W-1:0];
  assign div_zero  = dz_q;
  assign ovf       = ovf_q;
endmodule

// File: rtl/rdiv_unit_chk.sv
module rdiv_unit_chk #(
  parameter int W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [2*W-1:0] dividend,
  input logic [W-1:0]   divisor,
  input logic           busy,
  input logic           done,
  input logic [W-1:0]   quotient,
  input logic [W-1:0]   remainder,
  input logic           div_zero,
  input logic           ovf
);
  logic [W-1:0] seen_dvs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               seen_dvs_q <= '0;
    else if (start && !busy)  seen_dvs_q <= divisor;
  end

  // R1 / R3 / R4: the two flags are never raised together
  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(div_zero && ovf));

  // R3, R4: early exits report zero results
  assert_early_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (div_zero || ovf)) |-> (quotient == '0 && remainder == '0));

  // R5: remainder below the divisor accepted with the request
  assert_rem_below_div_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_zero && !ovf) |-> (remainder < seen_dvs_q));

  // R7: done and busy never overlap
  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R2 / R7: busy only rises after a request seen while idle
  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start) && !$past(busy)));

  // R8: results hold while idle with no new request
  assert_results_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$past(start)) |->
      ($stable(quotient) && $stable(remainder) && $stable(div_zero) && $stable(ovf)));
endmodule

bind rdiv_unit rdiv_unit_chk #(.W(W)) u_rdiv_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .dividend  (dividend),
  .divisor   (divisor),
  .busy      (busy),
  .done      (done),
  .quotient  (quotient),
  .remainder (remainder),
  .div_zero  (div_zero),
  .ovf       (ovf)
);

// File: tb/tb_rdiv_unit.sv
module tb_rdiv_unit;
  localparam int W        = 4;
  localparam int CLK_PERIOD = 10;
  localparam int MAXV     = 1 << W;

  logic           clk;
  logic           rst_n;
  logic           start;
  logic [2*W-1:0] dividend;
  logic [W-1:0]   divisor;
  logic           busy, done, div_zero, ovf;
  logic [W-1:0]   quotient, remainder;

  int n_cmp = 0;
  int n_bad = 0;
  bit summary_done = 0;

  rdiv_unit #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .div_zero(div_zero), .ovf(ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // One request; optional start pulse injected mid-division (R2).
  task automatic run_op(input int dvd, input int dvs, input bit poke, input string req);
    int eq, er, lat, ones;
    bit edz, eov;
    edz = (dvs == 0);
    eov = !edz && ((dvd >> W) >= dvs);
    eq = 0; er = 0; lat = 0;
    if (!edz && !eov) begin
      eq = dvd / dvs;
      er = dvd % dvs;
      ones = $countones(eq[W-1:0]);
      lat = W + (W - ones);   // R6: one restore per zero quotient bit
    end
    @(negedge clk);
    start    = 1'b1;
    dividend = (2*W)'(dvd);
    divisor  = W'(dvs);
    @(posedge clk);
    @(negedge clk);
    start    = 1'b0;
    dividend = ~dividend;
    divisor  = W'(dvs + 3);
    for (int j = 0; ; j++) begin
      chk("R7", "busy", int'(busy), int'(j < lat));
      chk("R6", "done", int'(done), int'(j == lat));
      if (j == lat) break;
      if (j > 3*W + 4) begin
        chk("R6", "watchdog", 0, 1);
        break;
      end
      if (poke && j == 1) begin
        start   = 1'b1;
        divisor = '0;
      end
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
    end
    chk(req, "quotient",  int'(quotient),  eq);
    chk(req, "remainder", int'(remainder), er);
    chk("R3", "div_zero", int'(div_zero), int'(edz));
    chk("R4", "ovf",      int'(ovf),      int'(eov));
    if (!edz && !eov) begin
      chk("R5", "q*d+r", int'(quotient) * dvs + int'(remainder), dvd);
      chk("R5", "r<d",   int'(int'(remainder) < dvs), 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk("R6", "global watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int hq, hr, hz, ho;
    rst_n    = 1'b0;
    start    = 1'b0;
    dividend = '0;
    divisor  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "div_zero", int'(div_zero), 0);
    chk("R1", "ovf", int'(ovf), 0);

    // R9: worked example, 147 / 11 -> 13 rem 4 in 5 cycles
    run_op(147, 11, 1'b0, "R9");
    chk("R9", "quotient 13", int'(quotient), 13);
    chk("R9", "remainder 4", int'(remainder), 4);

    // R2: start pulse with zero divisor while busy is ignored
    run_op(147, 11, 1'b1, "R2");
    run_op(100, 13, 1'b1, "R2");

    // R8: results hold while operand inputs move
    hq = int'(quotient); hr = int'(remainder); hz = int'(div_zero); ho = int'(ovf);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      dividend = (2*W)'(k * 37);
      divisor  = W'(k);
    end
    chk("R8", "held quotient",  int'(quotient),  hq);
    chk("R8", "held remainder", int'(remainder), hr);
    chk("R8", "held div_zero",  int'(div_zero),  hz);
    chk("R8", "held ovf",       int'(ovf),       ho);

    // R3 / R4 / R5 / R6: every operand pair
    for (int d = 0; d < MAXV; d++) begin
      for (int v = 0; v < MAXV * MAXV; v++) begin
        run_op(v, d, 1'b0, (d == 0) ? "R3" : (((v >> W) >= d) ? "R4" : "R5"));
      end
    end
    finish_run();
  end
endmodule